// File: doc/BRIEF.md
# Accumulator ALU with Carry Flag

This block is a 32-bit accumulator arithmetic unit with one carry status bit. Each clock it takes an operation code and a 16-bit operand. It can load the operand into either half of the accumulator, add or subtract the operand at either half, chain a carry or borrow into a following step, and force the carry to a fixed value. Results wrap modulo 2^32 and are never saturated.

Software builds 64-bit and wider add and subtract sequences out of 16-bit steps. The carry rules make this work. At the high half, an add can only raise the carry and a subtract can only drop it. A carry or borrow produced by an earlier low-half step therefore survives the high-half step that completes the same 32-bit word. All outputs are registered. An operation applied at one rising edge is visible right after that edge.

Top module: `acc_carry_alu`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both the accumulator and the carry.
- R2: Code 1 (load high) puts the operand in bits 31:16, zeroes bits 15:0 and leaves the carry unchanged.
- R3: Code 2 (load low) puts the operand in bits 15:0, zeroes bits 31:16 and leaves the carry unchanged.
- R4: Code 3 (add low) adds the operand, zero-extended into bits 15:0. The carry becomes the carry out of bit 31.
- R5: Code 4 (subtract low) subtracts the operand, zero-extended into bits 15:0. The carry becomes 1 when no borrow occurs and 0 when one does.
- R6: Code 5 (add high) adds the operand placed in bits 31:16. It sets the carry on a carry out of bit 31 and otherwise leaves the carry unchanged, so it never clears it.
- R7: Code 6 (subtract high) subtracts the operand placed in bits 31:16. It clears the carry on a borrow and otherwise leaves the carry unchanged, so it never sets it.
- R8: Code 7 (add with carry) adds the zero-extended operand plus the current carry, and the carry becomes the carry out. For example, 0xFFFFFFFF with carry 1, plus 0, gives 0x00000000 with carry 1.
- R9: Code 8 (subtract with borrow) subtracts the zero-extended operand plus the inverted carry, and the carry becomes the no-borrow flag. For example, 0x00000000 with carry 0, minus 0, gives 0xFFFFFFFF with carry 0.
- R10: Code 9 sets the carry and code 10 clears it. Both leave the accumulator unchanged.
- R11: Every arithmetic result wraps modulo 2^32 with no saturation.
- R12: Code 0 and codes 11 to 15 change neither the accumulator nor the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 4 | Operation code for this cycle |
| operand | input | 16 | Memory operand |
| accOut | output | 32 | Accumulator value |
| carryOut | output | 1 | Carry status bit |

## Verification
The bench builds the block with the default half width of 16, which gives the 32-bit accumulator. With that width, the all-ones and sign-boundary operands at both halves are in reach, and so are the worked carry and borrow cases at the high half. Chained 64-bit additions, built from eight 16-bit steps and checked against a 64-bit sum, show that a carry survives across the two halves. A long stream of random codes, including the unused ones, is compared with a behavioural model on every operation.

// File: rtl/acc_carry_pkg.sv
package acc_carry_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDHI  = 4'd1;
  localparam logic [OPC_W-1:0] OP_LDLO  = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADDLO = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUBLO = 4'd4;
  localparam logic [OPC_W-1:0] OP_ADDHI = 4'd5;
  localparam logic [OPC_W-1:0] OP_SUBHI = 4'd6;
  localparam logic [OPC_W-1:0] OP_ADDC  = 4'd7;
  localparam logic [OPC_W-1:0] OP_SUBB  = 4'd8;
  localparam logic [OPC_W-1:0] OP_SETC  = 4'd9;
  localparam logic [OPC_W-1:0] OP_CLRC  = 4'd10;

  // How the next carry is formed from the adder's carry out.
  typedef enum logic [2:0] {
    CM_KEEP = 3'd0,
    CM_OUT  = 3'd1,
    CM_OR   = 3'd2,
    CM_AND  = 3'd3,
    CM_ONE  = 3'd4,
    CM_ZERO = 3'd5
  } carryMode_e;

  typedef struct packed {
    logic       accWe;  // accumulator takes a new value
    logic       ldHi;   // load operand into upper half
    logic       ldLo;   // load operand into lower half
    logic       hiPos;  // arithmetic operand sits in upper half
    logic       sub;    // invert operand, subtract
    logic       cin;    // current carry feeds the adder
    carryMode_e cMode;
  } aluStrobe_t;

endpackage

// File: rtl/acc_carry_ctrl.sv
module acc_carry_ctrl
  import acc_carry_pkg::*;
(
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       strobe
);

  always_comb begin
    strobe = '{accWe: 1'b0, ldHi: 1'b0, ldLo: 1'b0, hiPos: 1'b0,
               sub: 1'b0, cin: 1'b0, cMode: CM_KEEP};
    case (opCode)
      OP_LDHI: begin
        strobe.accWe = 1'b1;
        strobe.ldHi  = 1'b1;
      end
      OP_LDLO: begin
        strobe.accWe = 1'b1;
        strobe.ldLo  = 1'b1;
      end
      OP_ADDLO: begin
        strobe.accWe = 1'b1;
        strobe.cMode = CM_OUT;
      end
      OP_SUBLO: begin
        strobe.accWe = 1'b1;
        strobe.sub   = 1'b1;
        strobe.cMode = CM_OUT;
      end
      OP_ADDHI: begin
        strobe.accWe = 1'b1;
        strobe.hiPos = 1'b1;
        strobe.cMode = CM_OR;
      end
      OP_SUBHI: begin
        strobe.accWe = 1'b1;
        strobe.hiPos = 1'b1;
        strobe.sub   = 1'b1;
        strobe.cMode = CM_AND;
      end
      OP_ADDC: begin
        strobe.accWe = 1'b1;
        strobe.cin   = 1'b1;
        strobe.cMode = CM_OUT;
      end
      OP_SUBB: begin
        strobe.accWe = 1'b1;
        strobe.sub   = 1'b1;
        strobe.cin   = 1'b1;
        strobe.cMode = CM_OUT;
      end
      OP_SETC: strobe.cMode = CM_ONE;
      OP_CLRC: strobe.cMode = CM_ZERO;
      default: ;
    endcase
  end

  // R2 R3: at most one load select at a time
  always_comb begin
    assert_one_load_R2: assert ($onehot0({strobe.ldHi, strobe.ldLo}));
  end

endmodule

// File: rtl/acc_carry_datapath.sv
module acc_carry_datapath
  import acc_carry_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  aluStrobe_t        strobe,
  input  logic [HALF_W-1:0] operand,
  output logic [2*HALF_W-1:0] accQ,
  output logic              carryQ
);

  localparam int ACC_W = 2 * HALF_W;

  logic [ACC_W-1:0] placed;
  logic [ACC_W-1:0] addend;
  logic             cinBit;
  logic [ACC_W:0]   sum;
  logic             cOut;
  logic [ACC_W-1:0] accNext;
  logic             carryNext;

  // Operand placement: upper half for high-half ops, else zero-extended low.
  assign placed = strobe.hiPos ? {operand, {HALF_W{1'b0}}}
                               : {{HALF_W{1'b0}}, operand};

  // One adder for both directions: subtract = add inverted operand.
  assign addend = strobe.sub ? ~placed : placed;
  assign cinBit = strobe.cin ? carryQ : strobe.sub;
  assign sum    = {1'b0, accQ} + {1'b0, addend} + {{ACC_W{1'b0}}, cinBit};
  assign cOut   = sum[ACC_W];  // carry on add, no-borrow on subtract

  always_comb begin
    if (strobe.ldHi)      accNext = {operand, {HALF_W{1'b0}}};
    else if (strobe.ldLo) accNext = {{HALF_W{1'b0}}, operand};
    else                  accNext = sum[ACC_W-1:0];
  end

  always_comb begin
    case (strobe.cMode)
      CM_OUT:  carryNext = cOut;
      CM_OR:   carryNext = carryQ | cOut;
      CM_AND:  carryNext = carryQ & cOut;
      CM_ONE:  carryNext = 1'b1;
      CM_ZERO: carryNext = 1'b0;
      default: carryNext = carryQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ   <= '0;
      carryQ <= 1'b0;
    end else begin
      if (strobe.accWe) accQ <= accNext;
      carryQ <= carryNext;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (accQ == '0 && !carryQ));

  assert_load_high_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.ldHi |=> (accQ[HALF_W-1:0] == '0 && $stable(carryQ)));

  assert_load_low_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.ldLo |=> (accQ[ACC_W-1:HALF_W] == '0 && $stable(carryQ)));

  assert_high_add_keeps_set_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.cMode == CM_OR && carryQ) |=> carryQ);

  assert_high_sub_keeps_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.cMode == CM_AND && !carryQ) |=> !carryQ);

  assert_set_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (strobe.cMode == CM_ONE) |=> (carryQ && $stable(accQ)));

  assert_clear_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (strobe.cMode == CM_ZERO) |=> (!carryQ && $stable(accQ)));

  assert_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (!strobe.accWe && strobe.cMode == CM_KEEP) |=> ($stable(accQ) && $stable(carryQ)));

endmodule

// File: rtl/acc_carry_alu.sv
module acc_carry_alu
  import acc_carry_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPC_W-1:0]    opCode,
  input  logic [HALF_W-1:0]   operand,
  output logic [2*HALF_W-1:0] accOut,
  output logic                carryOut
);

  aluStrobe_t strobe;

  acc_carry_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  acc_carry_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .operand (operand),
    .accQ    (accOut),
    .carryQ  (carryOut)
  );

endmodule

// File: tb/sim_acc_carry_alu.sv
module sim_acc_carry_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] operand = 16'd0;
  logic [31:0] accOut;
  logic        carryOut;

  longint unsigned mAcc = 0;
  bit              mC = 1'b0;
  int              checks = 0;
  int              errors = 0;
  bit              finished = 1'b0;

  localparam longint unsigned MASK = 64'hFFFF_FFFF;

  always #10 clk = ~clk;

  acc_carry_alu u0 (
    .clk      (clk),
    .rst      (rst),
    .opCode   (opCode),
    .operand  (operand),
    .accOut   (accOut),
    .carryOut (carryOut)
  );

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9, 4'd10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [15:0] d);
    longint unsigned v = 64'(d);
    longint unsigned t;
    case (op)
      4'd1: mAcc = v << 16;
      4'd2: mAcc = v;
      4'd3: begin t = mAcc + v; mC = t[32]; mAcc = t & MASK; end
      4'd4: begin mC = (mAcc >= v); mAcc = (mAcc - v) & MASK; end
      4'd5: begin t = mAcc + (v << 16); if (t[32]) mC = 1'b1; mAcc = t & MASK; end
      4'd6: begin if (mAcc < (v << 16)) mC = 1'b0; mAcc = (mAcc - (v << 16)) & MASK; end
      4'd7: begin t = mAcc + v + 64'(mC); mC = t[32]; mAcc = t & MASK; end
      4'd8: begin t = v + (mC ? 64'd0 : 64'd1); mC = (mAcc >= t); mAcc = (mAcc - t) & MASK; end
      4'd9: mC = 1'b1;
      4'd10: mC = 1'b0;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] expAcc, input bit expC);
    checks++;
    if (accOut !== expAcc || carryOut !== expC) begin
      errors++;
      $display("FAIL %s acc=%h c=%b expected acc=%h c=%b", req, accOut, carryOut, expAcc, expC);
    end
  endtask

  // Apply one operation, advance the model, compare right after the edge.
  task automatic step(input logic [3:0] op, input logic [15:0] d);
    @(negedge clk);
    opCode  = op;
    operand = d;
    @(posedge clk);
    model(op, d);
    #5;
    check(reqOf(op), mAcc[31:0], mC);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    opCode = 4'd0;
    @(posedge clk);
    #5;
    mAcc = 0;
    mC = 1'b0;
    check("R1", 32'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic add64(input logic [63:0] x, input logic [63:0] y);
    logic [31:0] lo;
    logic [63:0] expSum;
    step(4'd1, x[31:16]);
    step(4'd3, x[15:0]);
    step(4'd3, y[15:0]);
    step(4'd5, y[31:16]);
    lo = accOut;
    step(4'd1, x[63:48]);
    step(4'd8 - 4'd1, x[47:32]);
    step(4'd3, y[47:32]);
    step(4'd5, y[63:48]);
    expSum = x + y;
    checks++;
    if ({accOut, lo} !== expSum) begin
      errors++;
      $display("FAIL R8 R6 sum64=%h expected %h", {accOut, lo}, expSum);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(posedge clk);
    #5;
    check("R1", 32'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3: loads, carry untouched
    step(4'd9, 16'h0);
    step(4'd1, 16'hABCD);
    check("R2", 32'hABCD_0000, 1'b1);
    step(4'd2, 16'h1234);
    check("R3", 32'h0000_1234, 1'b1);

    // R4 R11: low add, wrap to zero with carry
    step(4'd1, 16'hFFFF);
    step(4'd3, 16'hFFFF);
    check("R4", 32'hFFFF_FFFF, 1'b0);
    step(4'd3, 16'h0001);
    check("R11", 32'h0000_0000, 1'b1);

    // R5: low subtract with borrow from zero
    step(4'd3, 16'h0000);
    step(4'd4, 16'h0001);
    check("R5", 32'hFFFF_FFFF, 1'b0);

    // R6: high add keeps carry set; adds into upper half
    step(4'd1, 16'h8000);
    step(4'd3, 16'hFFFF);
    step(4'd9, 16'h0);
    step(4'd5, 16'h0000);
    check("R6", 32'h8000_FFFF, 1'b1);
    step(4'd5, 16'h7FFF);
    check("R6", 32'hFFFF_FFFF, 1'b1);
    step(4'd10, 16'h0);
    step(4'd5, 16'h0001);
    check("R6", 32'h0000_FFFF, 1'b1);

    // R7: high subtract keeps carry clear; clears on borrow
    step(4'd1, 16'h8000);
    step(4'd3, 16'hFFFF);
    step(4'd10, 16'h0);
    step(4'd6, 16'h0001);
    check("R7", 32'h7FFF_FFFF, 1'b0);
    step(4'd1, 16'h8000);
    step(4'd3, 16'hFFFF);
    step(4'd10, 16'h0);
    step(4'd6, 16'hFFFF);
    check("R7", 32'h8001_FFFF, 1'b0);
    step(4'd9, 16'h0);
    step(4'd6, 16'h0001);
    check("R7", 32'h8000_FFFF, 1'b1);

    // R8: add with carry
    step(4'd1, 16'hFFFF);
    step(4'd3, 16'hFFFF);
    step(4'd9, 16'h0);
    step(4'd7, 16'h0000);
    check("R8", 32'h0000_0000, 1'b1);

    // R9: subtract with borrow
    step(4'd10, 16'h0);
    step(4'd9 - 4'd1, 16'h0000);
    check("R9", 32'hFFFF_FFFF, 1'b0);
    step(4'd9, 16'h0);
    step(4'd8, 16'h0001);
    check("R9", 32'hFFFF_FFFE, 1'b1);

    // R10: carry control leaves accumulator
    step(4'd9, 16'h5555);
    check("R10", 32'hFFFF_FFFE, 1'b1);
    step(4'd10, 16'h5555);
    check("R10", 32'hFFFF_FFFE, 1'b0);

    // R12: idle and unused codes
    for (int k = 11; k < 16; k++) step(4'(k), 16'hFFFF);
    step(4'd0, 16'hFFFF);
    check("R12", 32'hFFFF_FFFE, 1'b0);

    // R1: reset mid-run
    step(4'd9, 16'h0);
    step(4'd1, 16'h7777);
    doReset();

    // R6 R8: chained 64-bit additions
    add64(64'h0001_FFFF_FFFF_FFFF, 64'h1);
    add64(64'h89AB_CDEF_0123_4567, 64'hFEDC_BA98_7654_3210);
    for (int k = 0; k < 20; k++)
      add64({$urandom, $urandom}, {$urandom, $urandom});

    // All requirements: random stream against the model
    for (int k = 0; k < 600; k++)
      step(4'($urandom_range(0, 15)), 16'($urandom));

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule